// File: doc/BRIEF.md
# Page Access Lock and Protection Checker

This block sits right after address translation. For each memory reference it judges the selected 16-bit page descriptor word. It compares the descriptor's lock code with the requester's key. It also applies the per-page execute-inhibit or store-inhibit flag, depending on what the reference is doing. The answer comes back in the same cycle, so the memory controller can stop a fetch or suppress a store before anything changes.

The key comes from one of two places. When the processor makes the reference, the key is the processor-state key from the status word. When a DMA device using logical addressing makes it, the device supplies its own key. Every denial raises a one-cycle fault strobe. At the next clock edge the denial also sets a sticky bit in a small fault register: the processor bit or the DMA bit, depending on the kind of fault and who caused it. While either bit is set, a machine-error interrupt request stays raised until software pulses the clear input.

Top module: `page_access_guard`

## Requirements
- R1: The descriptor word is split as follows: lock code in `page_word[15:12]`, protect flag in `page_word[11]`, reserved bits in `page_word[10:8]`, and physical page in `page_word[7:0]`. The reserved bits and the physical page have no effect on any output.
- R2: With the lock feature enabled (`LOCK_EN=1`), the key is checked against the lock as follows. Lock value 4'hF accepts every key. Key 4'h0 is accepted by every lock. Keys 4'h1 to 4'hE are accepted only by an equal lock. Key 4'hF is accepted only by lock 4'hF. Any other pairing raises `access_fault`.
- R3: The key used is `cpu_key` when `req_dma=0` and `dev_key` when `req_dma=1`. The key not selected has no effect.
- R4: `ref_kind` is encoded as 2'b00 operand read, 2'b01 instruction fetch, 2'b10 write and 2'b11 operand read. An instruction fetch through a descriptor whose flag is 1 raises `exec_fault`.
- R5: A write through a descriptor whose flag is 1 raises `wprot_fault`. Operand reads ignore the flag, and so do fetches as far as write protection is concerned.
- R6: `permit` is 1 in the same cycle exactly when `ref_valid=1` and no fault strobe is high. `write_commit` equals `permit` AND (kind is write), so a denied write never commits.
- R7: At the next rising clock edge, faults set sticky bits. Access and write-protect faults set `fault_bits[0]` for a processor reference and `fault_bits[1]` for a DMA reference. Execute-protect faults always set `fault_bits[0]`.
- R8: Fault bits stay set until a cycle with `flt_clr=1` clears them. A fault in that same cycle still sets its bit.
- R9: `mach_err_irq` is 1 whenever any fault bit is set.
- R10: With `ref_valid=0`, all strobes and `permit` are 0 and the fault bits are unchanged.
- R11: With `LOCK_EN=0`, the lock field is ignored and `access_fault` never rises. Execute and write protection still apply.
- R12: After reset, `fault_bits` is 0 and `mach_err_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_kind | input | 2 | Reference kind (R4 encoding) |
| req_dma | input | 1 | 1 = DMA requester, 0 = processor |
| cpu_key | input | 4 | Processor-state key from the status word |
| dev_key | input | 4 | Key supplied by a DMA device |
| page_word | input | 16 | Selected page descriptor word |
| flt_clr | input | 1 | Clears the sticky fault bits |
| permit | output | 1 | Reference allowed |
| write_commit | output | 1 | Permitted write may modify memory |
| access_fault | output | 1 | Lock/key mismatch strobe |
| exec_fault | output | 1 | Execute-protect strobe |
| wprot_fault | output | 1 | Write-protect strobe |
| fault_bits | output | 2 | Sticky faults: [0] processor, [1] DMA |
| mach_err_irq | output | 1 | Machine-error interrupt request |

## Verification
The bench builds two copies of the block. One has `LOCK_EN=1`, which exposes the whole 16x16 lock/key acceptance matrix, the key-source multiplexing and the fault routing by requester. The other has `LOCK_EN=0`, where the lock field must be ignored entirely while the flag-based protection keeps working. Both run with two reset synchronizer stages. Together they cover fault routing, sticky clearing with a fault in the same cycle, and reserved-bit insensitivity.

// File: rtl/page_guard_pkg.sv
package page_guard_pkg;
  localparam int WORD_W   = 16;
  localparam int KEY_W    = 4;
  localparam int LOCK_MSB = 15;
  localparam int LOCK_LSB = 12;
  localparam int FLAG_BIT = 11;
  localparam int FLT_W    = 2;
  localparam int FLT_CPU  = 0;
  localparam int FLT_DMA  = 1;

  typedef enum logic [1:0] {
    REF_OPRD   = 2'b00,
    REF_IFETCH = 2'b01,
    REF_WRITE  = 2'b10,
    REF_OPRD2  = 2'b11
  } ref_kind_e;

  typedef struct packed {
    logic acc;
    logic exe;
    logic wpr;
  } fault_vec_t;
endpackage

// File: rtl/pg_reset_sync.sv
module pg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pg_lock_match.sv
module pg_lock_match
  import page_guard_pkg::*;
#(
  parameter bit LOCK_EN = 1'b1
) (
  input  logic [KEY_W-1:0] lock_code,
  input  logic [KEY_W-1:0] key_code,
  output logic             key_ok
);
  localparam logic [KEY_W-1:0] OPEN_LOCK  = '1;
  localparam logic [KEY_W-1:0] MASTER_KEY = '0;

  generate
    if (LOCK_EN) begin : g_lock
      logic open_l, master_k, exact;
      always_comb begin
        open_l   = (lock_code == OPEN_LOCK);
        master_k = (key_code == MASTER_KEY);
        exact    = (key_code == lock_code);
        key_ok   = open_l | master_k | exact;
      end
    end else begin : g_nolock
      logic [2*KEY_W-1:0] unused_bits;
      assign unused_bits = {lock_code, key_code};
      assign key_ok = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pg_protect_eval.sv
module pg_protect_eval
  import page_guard_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] kind,
  input  logic       flag,
  input  logic       key_ok,
  output fault_vec_t faults
);
  ref_kind_e k;
  always_comb begin
    k = ref_kind_e'(kind);
    faults.acc = valid & ~key_ok;
    faults.exe = valid & flag & (k == REF_IFETCH);
    faults.wpr = valid & flag & (k == REF_WRITE);
  end
endmodule

// File: rtl/pg_fault_reg.sv
module pg_fault_reg
  import page_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_cpu,
  input  logic             set_dma,
  input  logic             clr,
  output logic [FLT_W-1:0] bits,
  output logic             irq
);
  logic [FLT_W-1:0] flt_q, flt_d, set_v;
  logic             upd_en;

  always_comb begin
    set_v          = '0;
    set_v[FLT_CPU] = set_cpu;
    set_v[FLT_DMA] = set_dma;
    upd_en         = clr | (|set_v);
    flt_d          = (clr ? '0 : flt_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flt_q <= '0;
    else if (upd_en) flt_q <= flt_d;
  end

  assign bits = flt_q;
  assign irq  = |flt_q;

  a_r8_sticky_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q[FLT_CPU] && !clr) |=> flt_q[FLT_CPU]);
  a_r8_sticky_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q[FLT_DMA] && !clr) |=> flt_q[FLT_DMA]);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_cpu && !set_dma) |=> (flt_q == '0));
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_dma |=> flt_q[FLT_DMA]);
endmodule

// File: rtl/page_access_guard.sv
module page_access_guard
  import page_guard_pkg::*;
#(
  parameter bit LOCK_EN     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [1:0]        ref_kind,
  input  logic              req_dma,
  input  logic [KEY_W-1:0]  cpu_key,
  input  logic [KEY_W-1:0]  dev_key,
  input  logic [WORD_W-1:0] page_word,
  input  logic              flt_clr,
  output logic              permit,
  output logic              write_commit,
  output logic              access_fault,
  output logic              exec_fault,
  output logic              wprot_fault,
  output logic [FLT_W-1:0]  fault_bits,
  output logic              mach_err_irq
);
  logic             rst_s_n;
  logic [KEY_W-1:0] eff_key;
  logic [KEY_W-1:0] lock_fld;
  logic             prot_flag;
  logic             key_ok;
  fault_vec_t       fv;
  logic             set_cpu, set_dma;

  pg_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  always_comb begin
    eff_key   = req_dma ? dev_key : cpu_key;
    lock_fld  = page_word[LOCK_MSB:LOCK_LSB];
    prot_flag = page_word[FLAG_BIT];
  end

  pg_lock_match #(.LOCK_EN(LOCK_EN)) u_match (
    .lock_code(lock_fld), .key_code(eff_key), .key_ok(key_ok));

  pg_protect_eval u_prot (
    .valid(ref_valid), .kind(ref_kind), .flag(prot_flag),
    .key_ok(key_ok), .faults(fv));

  always_comb begin
    access_fault = fv.acc;
    exec_fault   = fv.exe;
    wprot_fault  = fv.wpr;
    permit       = ref_valid & ~(fv.acc | fv.exe | fv.wpr);
    write_commit = permit & (ref_kind_e'(ref_kind) == REF_WRITE);
    set_cpu      = fv.exe | (~req_dma & (fv.acc | fv.wpr));
    set_dma      = req_dma & (fv.acc | fv.wpr);
  end

  pg_fault_reg u_freg (
    .clk(clk), .rst_n(rst_s_n), .set_cpu(set_cpu), .set_dma(set_dma),
    .clr(flt_clr), .bits(fault_bits), .irq(mach_err_irq));

  a_r2_master_key: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ref_valid && eff_key == '0) |-> !access_fault);
  a_r2_open_lock: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ref_valid && page_word[LOCK_MSB:LOCK_LSB] == '1) |-> !access_fault);
  a_r4_exec_block: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ref_valid && ref_kind == 2'b01 && page_word[FLAG_BIT]) |-> (exec_fault && !permit));
  a_r6_no_denied_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    !permit |-> !write_commit);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ref_valid |-> (!access_fault && !exec_fault && !wprot_fault && !permit));
  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(fault_bits[1]) |-> mach_err_irq);
endmodule

// File: tb/test_page_access_guard.sv
module test_page_access_guard;
  logic clk = 1'b0;
  logic rst_n;
  logic ref_valid, req_dma, flt_clr;
  logic [1:0]  ref_kind;
  logic [3:0]  cpu_key, dev_key;
  logic [15:0] page_word;
  logic permit, write_commit, access_fault, exec_fault, wprot_fault, mach_err_irq;
  logic [1:0] fault_bits;
  logic n_permit, n_wc, n_acc, n_exe, n_wpr, n_irq;
  logic [1:0] n_bits;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #5 clk = ~clk;

  page_access_guard #(.LOCK_EN(1'b1), .SYNC_STAGES(2)) i_page_access_guard (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_kind(ref_kind),
    .req_dma(req_dma), .cpu_key(cpu_key), .dev_key(dev_key),
    .page_word(page_word), .flt_clr(flt_clr), .permit(permit),
    .write_commit(write_commit), .access_fault(access_fault),
    .exec_fault(exec_fault), .wprot_fault(wprot_fault),
    .fault_bits(fault_bits), .mach_err_irq(mach_err_irq));

  page_access_guard #(.LOCK_EN(1'b0), .SYNC_STAGES(2)) i_page_access_guard_nolock (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_kind(ref_kind),
    .req_dma(req_dma), .cpu_key(cpu_key), .dev_key(dev_key),
    .page_word(page_word), .flt_clr(flt_clr), .permit(n_permit),
    .write_commit(n_wc), .access_fault(n_acc),
    .exec_fault(n_exe), .wprot_fault(n_wpr),
    .fault_bits(n_bits), .mach_err_irq(n_irq));

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit key_fits(logic [3:0] lock, logic [3:0] key);
    if (lock == 4'hF) return 1'b1;
    if (key == 4'h0) return 1'b1;
    return (key == lock);
  endfunction

  task automatic idle();
    @(negedge clk);
    ref_valid = 0; flt_clr = 0; req_dma = 0; ref_kind = 2'b00;
    cpu_key = 0; dev_key = 0; page_word = 16'h0000;
  endtask

  task automatic clear_faults();
    @(negedge clk);
    ref_valid = 0; flt_clr = 1;
    @(negedge clk);
    flt_clr = 0;
  endtask

  task automatic present(logic dma, logic [1:0] kind, logic [3:0] ck,
                         logic [3:0] dk, logic [15:0] pw);
    @(negedge clk);
    ref_valid = 1; req_dma = dma; ref_kind = kind;
    cpu_key = ck; dev_key = dk; page_word = pw; flt_clr = 0;
    #1;
  endtask

  task automatic t_reset();
    chk("R12 fault_bits", fault_bits, 0);
    chk("R12 irq", mach_err_irq, 0);
    chk("R10 idle permit", permit, 0);
    chk("R10 idle strobes", {access_fault, exec_fault, wprot_fault}, 0);
  endtask

  task automatic t_matrix();
    for (int l = 0; l < 16; l++) begin
      for (int k = 0; k < 16; k++) begin
        present(1'b0, 2'b00, k[3:0], 4'h0, {l[3:0], 12'h0AB});
        chk($sformatf("R2 lock %0h key %0h", l, k), access_fault,
            key_fits(l[3:0], k[3:0]) ? 0 : 1);
        chk("R6 permit", permit, key_fits(l[3:0], k[3:0]) ? 1 : 0);
        chk("R11 no access fault", n_acc, 0);
      end
    end
    idle();
    clear_faults();
  endtask

  task automatic t_key_source();
    present(1'b0, 2'b00, 4'h5, 4'h3, 16'h5000);
    chk("R3 cpu key used", access_fault, 0);
    present(1'b1, 2'b00, 4'h5, 4'h3, 16'h5000);
    chk("R3 dev key used", access_fault, 1);
    present(1'b1, 2'b00, 4'h9, 4'h5, 16'h5000);
    chk("R3 cpu key ignored for dma", access_fault, 0);
    idle();
    clear_faults();
  endtask

  task automatic t_exec();
    present(1'b0, 2'b01, 4'h0, 4'h0, 16'hF800);
    chk("R4 exec fault", exec_fault, 1);
    chk("R4 no permit", permit, 0);
    chk("R11 exec still applies", n_exe, 1);
    chk("R5 fetch not write fault", wprot_fault, 0);
    present(1'b0, 2'b01, 4'h0, 4'h0, 16'hF000);
    chk("R4 flag clear fetch ok", permit, 1);
    present(1'b0, 2'b00, 4'h0, 4'h0, 16'hF800);
    chk("R5 read ignores flag", permit, 1);
    present(1'b0, 2'b11, 4'h0, 4'h0, 16'hF800);
    chk("R4 kind 11 is read", permit, 1);
    idle();
    clear_faults();
  endtask

  task automatic t_write();
    present(1'b0, 2'b10, 4'h0, 4'h0, 16'hF800);
    chk("R5 write fault", wprot_fault, 1);
    chk("R6 no commit", write_commit, 0);
    present(1'b0, 2'b10, 4'h0, 4'h0, 16'hF000);
    chk("R6 write commits", write_commit, 1);
    present(1'b0, 2'b10, 4'h2, 4'h0, 16'h3000);
    chk("R6 locked write no commit", write_commit, 0);
    present(1'b0, 2'b00, 4'h0, 4'h0, 16'hF000);
    chk("R6 read no commit", write_commit, 0);
    idle();
    clear_faults();
  endtask

  task automatic t_reserved();
    present(1'b0, 2'b10, 4'h6, 4'h0, 16'h6700);
    chk("R1 reserved ignored", {permit, access_fault, wprot_fault}, 3'b100);
    present(1'b0, 2'b10, 4'h6, 4'h0, 16'h60FF);
    chk("R1 page ignored", {permit, access_fault, wprot_fault}, 3'b100);
    idle();
    chk("R1 no fault bits", fault_bits, 0);
  endtask

  task automatic t_routing();
    present(1'b0, 2'b00, 4'h1, 4'h0, 16'h2000);
    @(negedge clk); ref_valid = 0; #1;
    chk("R7 cpu access to bit0", fault_bits, 2'b01);
    chk("R9 irq", mach_err_irq, 1);
    clear_faults(); #1;
    chk("R8 cleared", fault_bits, 0);
    chk("R9 irq low", mach_err_irq, 0);
    present(1'b1, 2'b00, 4'h0, 4'h1, 16'h2000);
    @(negedge clk); ref_valid = 0; #1;
    chk("R7 dma access to bit1", fault_bits, 2'b10);
    clear_faults();
    present(1'b1, 2'b10, 4'h0, 4'h0, 16'hF800);
    @(negedge clk); ref_valid = 0; #1;
    chk("R7 dma write to bit1", fault_bits, 2'b10);
    clear_faults();
    present(1'b1, 2'b01, 4'h0, 4'h0, 16'hF800);
    @(negedge clk); ref_valid = 0; #1;
    chk("R7 dma exec to bit0", fault_bits, 2'b01);
    clear_faults();
    present(1'b0, 2'b10, 4'h0, 4'h0, 16'hF800);
    @(negedge clk); ref_valid = 0; #1;
    chk("R7 cpu write to bit0", fault_bits, 2'b01);
    clear_faults();
  endtask

  task automatic t_sticky();
    present(1'b0, 2'b00, 4'h3, 4'h0, 16'h4000);
    @(negedge clk); ref_valid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 sticky", fault_bits, 2'b01);
    present(1'b0, 2'b01, 4'h0, 4'h0, 16'h0800);
    chk("R10 fetch faulted", exec_fault, 1);
    @(negedge clk); ref_valid = 0; #1;
    chk("R8 sticky after more", fault_bits, 2'b01);
    present(1'b1, 2'b00, 4'h0, 4'hF, 16'h4000);
    flt_clr = 1;
    @(negedge clk); ref_valid = 0; flt_clr = 0; #1;
    chk("R8 set beats clear", fault_bits, 2'b10);
    @(negedge clk);
    present(1'b1, 2'b00, 4'h0, 4'hF, 16'h4000);
    ref_valid = 0; #1;
    chk("R10 invalid no strobe", access_fault, 0);
    @(negedge clk); #1;
    chk("R10 invalid no update", fault_bits, 2'b10);
    clear_faults(); #1;
    chk("R8 final clear", fault_bits, 0);
  endtask

  initial begin
    rst_n = 0; ref_valid = 0; flt_clr = 0; req_dma = 0; ref_kind = 0;
    cpu_key = 0; dev_key = 0; page_word = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_matrix();
    t_key_source();
    t_exec();
    t_write();
    t_reserved();
    t_routing();
    t_sticky();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule